// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It takes one multiplier bit per clock. The multiplier's low bit and the bit that was shifted out just before it are recoded into one of three actions on the upper half of the running product: add the multiplicand, subtract it, or leave the upper half unchanged. An arithmetic right shift of the upper half, the multiplier and the extra bit then follows. Negative operands need no sign correction before or after the run.

A caller loads both operands and pulses `start` while the block is idle. `busy` stays high for exactly `WIDTH` cycles. `done` then pulses for one cycle. The product is valid from that pulse and holds until the next accepted start. A `start` that arrives during a run is ignored.

Top module: `boothMultiplier`

## Requirements
- R1: After reset `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle for exactly `WIDTH` cycles.
- R3: `done` is high for exactly one cycle, in the first cycle after `busy` falls. It is never high together with `busy`.
- R4: When `done` is high, `product` holds the signed `2*WIDTH`-bit product of `multiplicand` and `multiplier` as sampled at the accepted start. All four sign combinations are covered.
- R5: A `start` pulse, or a change of the operand inputs, while `busy` is high has no effect on the result or on the timing of the run in progress.
- R6: The action for each step is chosen from the multiplier's low bit and the extra bit, written as {low bit, extra bit}. 10 subtracts the multiplicand. 01 adds it. 00 and 11 only shift. The subtraction adds the two's complement. With 4-bit operands, 7 times 3 gives 21 (8'h15).
- R7: The most negative multiplier value gives the correct signed product. With 4-bit operands, -8 times 5 gives -40.
- R8: The most negative multiplicand value gives the correct signed product. With 4-bit operands, -8 times -8 gives 64, and -8 times 1 gives -8.
- R9: While `busy` is low and no start is accepted, `product` stays stable and `done` stays low after its single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; taken only while idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled at an accepted start |
| multiplier | input | WIDTH | Signed multiplier, sampled at an accepted start |
| busy | output | 1 | High while the recode-and-shift steps run |
| done | output | 1 | One-cycle pulse marking the product valid |
| product | output | 2*WIDTH | Signed product, upper half then lower half |

## Verification
The bench sweeps every pair of 4-bit signed operands. A recoder that swaps the add and subtract cases therefore shows up as sign and magnitude errors across most of the table. A logical shift in place of an arithmetic one corrupts every negative partial product. The extreme operands get dedicated cases. If the sum were taken without a guard bit, the most negative multiplicand would overflow the upper half and give, for example, +8 for -8 times 1. A step counter that is off by one would stretch or shorten `busy` and leave the product scaled by a factor of two. A run interrupted by a second start checks that a design which reloads mid-run returns the wrong product.

// File: rtl/boothMulPkg.sv
package boothMulPkg;

  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } boothOp_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/boothRecode.sv
module boothRecode
  import boothMulPkg::*;
(
  input  logic     lowBit,
  input  logic     prevBit,
  output boothOp_t op
);

  always_comb begin
    unique case ({lowBit, prevBit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_KEEP;
    endcase
  end

endmodule

// File: rtl/boothMulDatapath.sv
module boothMulDatapath
  import boothMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [WIDTH-1:0]   loadMcand,
  input  logic [WIDTH-1:0]   loadMplier,
  output logic [2*WIDTH-1:0] productOut
);

  localparam int EXT = WIDTH + 1;

  logic [WIDTH-1:0] accReg;
  logic [WIDTH-1:0] mplierReg;
  logic [WIDTH-1:0] mcandReg;
  logic             extraBit;

  boothOp_t         stepOp;
  logic [EXT-1:0]   accExt;
  logic [EXT-1:0]   mcandExt;
  logic [EXT-1:0]   addend;
  logic             carryIn;
  logic [EXT-1:0]   partialSum;

  boothRecode u_recode (
    .lowBit  (mplierReg[0]),
    .prevBit (extraBit),
    .op      (stepOp)
  );

  // Guard bit: the sum is formed one bit wider so that its true sign is
  // shifted in even when the multiplicand is the most negative value.
  always_comb begin
    accExt   = {accReg[WIDTH-1], accReg};
    mcandExt = {mcandReg[WIDTH-1], mcandReg};
    unique case (stepOp)
      OP_ADD: begin
        addend  = mcandExt;
        carryIn = 1'b0;
      end
      OP_SUB: begin
        addend  = ~mcandExt;
        carryIn = 1'b1;
      end
      default: begin
        addend  = '0;
        carryIn = 1'b0;
      end
    endcase
    partialSum = accExt + addend + {{(EXT-1){1'b0}}, carryIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg    <= '0;
      mplierReg <= '0;
      mcandReg  <= '0;
      extraBit  <= 1'b0;
    end else if (strobe.load) begin
      accReg    <= '0;
      mplierReg <= loadMplier;
      mcandReg  <= loadMcand;
      extraBit  <= 1'b0;
    end else if (strobe.step) begin
      accReg    <= partialSum[EXT-1:1];
      mplierReg <= {partialSum[0], mplierReg[WIDTH-1:1]};
      extraBit  <= mplierReg[0];
    end
  end

  assign productOut = {accReg, mplierReg};

endmodule

// File: rtl/boothMulCtrl.sv
module boothMulCtrl
  import boothMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = $clog2(WIDTH) + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] stepCnt;
  logic             accept;
  logic             finalStep;

  assign accept    = (state == ST_IDLE) && start;
  assign finalStep = (state == ST_RUN) && (stepCnt == LAST_STEP);

  always_comb begin
    strobe.load = accept;
    strobe.step = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= finalStep;
      if (accept) begin
        state   <= ST_RUN;
        stepCnt <= '0;
      end else if (finalStep) begin
        state   <= ST_IDLE;
      end else if (state == ST_RUN) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/boothMultiplier.sv
module boothMultiplier
  import boothMulPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  dpStrobe_t dpStrobe;

  boothMulCtrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (dpStrobe),
    .busy   (busy),
    .done   (done)
  );

  boothMulDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (dpStrobe),
    .loadMcand  (multiplicand),
    .loadMplier (multiplier),
    .productOut (product)
  );

endmodule

// File: rtl/boothMulChecker.sv
module boothMulChecker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int CNT_W = $clog2(WIDTH) + 2;

  logic signed [2*WIDTH-1:0] heldA;
  logic signed [2*WIDTH-1:0] heldB;
  logic signed [2*WIDTH-1:0] refProd;
  logic [CNT_W-1:0]          busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldA   <= '0;
      heldB   <= '0;
      busyCnt <= '0;
    end else if (start && !busy) begin
      heldA   <= {{WIDTH{multiplicand[WIDTH-1]}}, multiplicand};
      heldB   <= {{WIDTH{multiplier[WIDTH-1]}}, multiplier};
      busyCnt <= '0;
    end else if (busy) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  assign refProd = heldA * heldB;

  always_comb begin
    if (!rstN) begin
      assert_reset_idle_R1: assert (!busy && !done && product == '0);
    end
  end

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == CNT_W'(WIDTH)));

  assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_product_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product == refProd));

  assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

endmodule

bind boothMultiplier boothMulChecker #(.WIDTH(WIDTH)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/test_boothMultiplier.sv
`timescale 1ns/1ps
module test_boothMultiplier;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   multiplicand = '0;
  logic [W-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boothMultiplier #(.WIDTH(W)) i_boothMultiplier (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  task automatic check(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic logic [2*W-1:0] refMul(input int a, input int b);
    int p;
    p = a * b;
    return p[2*W-1:0];
  endfunction

  // Runs one multiplication, optionally pulsing start and changing operands mid-run.
  task automatic runMul(input int a, input int b, input string req, input bit disturb);
    logic [2*W-1:0] exp;
    exp = refMul(a, b);
    @(negedge clk);
    multiplicand = W'(a);
    multiplier   = W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= W; k++) begin
      if (busy !== 1'b1 || done !== 1'b0) begin
        check({req, " R2 busy window"}, {busy, done}, 2'b10);
      end
      if (disturb && k == 2) begin
        start = 1'b1;
        multiplicand = ~multiplicand;
        multiplier   = multiplier + 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check({req, " R3 done pulse"}, {busy, done}, 2'b01);
    check({req, " R4 product"}, product, exp);
  endtask

  task automatic testReset();
    check("R1 reset busy/done", {busy, done}, 2'b00);
    check("R1 reset product", product, '0);
  endtask

  task automatic testWorkedCase();
    runMul(7, 3, "R6 7x3", 1'b0);
    check("R6 7x3 equals 0x15", product, 8'h15);
    runMul(-7, 3, "R4 neg x pos", 1'b0);
    runMul(7, -3, "R4 pos x neg", 1'b0);
    runMul(-7, -3, "R4 neg x neg", 1'b0);
    runMul(5, 6, "R6 alternating pairs", 1'b0);
  endtask

  task automatic testExtremes();
    runMul(5, -8, "R7 mplier min", 1'b0);
    check("R7 5 x -8", product, 8'hD8);
    runMul(-8, 1, "R8 mcand min x1", 1'b0);
    check("R8 -8 x 1", product, 8'hF8);
    runMul(-8, -8, "R8 min x min", 1'b0);
    check("R8 -8 x -8", product, 8'h40);
    runMul(-8, 7, "R8 min x max", 1'b0);
  endtask

  task automatic testStartWhileBusy();
    runMul(6, -5, "R5 disturbed run", 1'b1);
    check("R5 result unaffected", product, refMul(6, -5));
  endtask

  task automatic testHold();
    logic [2*W-1:0] snap;
    runMul(-3, 7, "R9 setup", 1'b0);
    snap = product;
    multiplicand = 4'h2;
    multiplier   = 4'h2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 done low when idle", {busy, done}, 2'b00);
      check("R9 product held", product, snap);
    end
  endtask

  task automatic testExhaustive();
    for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
      for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++) begin
        runMul(a, b, "R4 sweep", 1'b0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWorkedCase();
    testExtremes();
    testStartWhileBusy();
    testHold();
    testExhaustive();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule